// File: doc/BRIEF.md
# Shared Interrupt Program-Counter Switch

This block gives interrupts to a processor whose program counter is one entry of its register file. Each expansion slot drives its own request line. The lines are OR-ed into one shared request. When interrupts are enabled and that request is present at an instruction fetch boundary, the block changes the register index that the core uses as its program counter. The main register R7 is replaced by the service register R6. Software must load R6 with the service-routine entry address before it enables interrupts. The return address stays untouched in R7, so no stack push is needed.

The priority among the slots is fixed by position: the lowest requesting slot number wins. Its index is captured at the moment of the switch and stays visible until the next switch. While the core runs from R6, further requests and boundaries are ignored. A clear strobe, issued by the service routine when it finishes, acknowledges the interrupt and hands the program counter back to R7.

The controller has two states. MAIN_PC drives index 7. SERVICE_PC drives index 6. The transition TAKE goes from MAIN_PC to SERVICE_PC when the enable flag is set, some slot is requesting and `fetch_bnd` is high. The transition RETURN goes from SERVICE_PC to MAIN_PC when `irq_clr_stb` is high. In every other case each state holds.

Top module: `irq_pc_switch`

## Requirements
- R1: After reset, `pc_sel` is 7, `win_slot` is 0 and interrupts are disabled.
- R2: In MAIN_PC, when the enable flag is set, any `slot_req` bit is high and `fetch_bnd` is high at a rising edge, `pc_sel` reads 6 from that edge on.
- R3: In MAIN_PC, a pending enabled request with `fetch_bnd` low does not change `pc_sel`.
- R4: While the enable flag is clear, requests at fetch boundaries leave `pc_sel` at 7.
- R5: On TAKE, `win_slot` becomes the lowest-numbered slot whose `slot_req` bit is high (bit i of `slot_req` is slot i).
- R6: In SERVICE_PC without `irq_clr_stb`, `pc_sel` stays 6 and `win_slot` is unchanged, whatever the requests and boundaries are.
- R7: In SERVICE_PC, `irq_clr_stb` returns `pc_sel` to 7 at that edge. This holds even if a request and a boundary arrive in the same cycle.
- R8: `irq_clr_stb` in MAIN_PC has no effect on `pc_sel` or `win_slot`.
- R9: `irq_en_stb` sets the enable flag and `irq_dis_stb` clears it. If both arrive in the same cycle, the flag ends up clear.
- R10: After RETURN, `win_slot` keeps the last winner until the next TAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_req | input | NUM_SLOTS | Per-slot interrupt request, bit i is slot i |
| irq_en_stb | input | 1 | Enable-interrupts strobe |
| irq_dis_stb | input | 1 | Disable-interrupts strobe |
| irq_clr_stb | input | 1 | Acknowledge and return-to-main strobe |
| fetch_bnd | input | 1 | High in the cycle that is an instruction fetch boundary |
| pc_sel | output | REG_IDX_W | Register-file index acting as program counter |
| win_slot | output | SLOT_W | Slot number latched at the last TAKE |

## Verification
The request vectors include a single high slot, a single low slot, two requests at once and all slots at once. Together they show whether the encoder favours low numbers and whether it reaches both ends of the slot range. Requests are presented in three situations: with the flag clear, away from a boundary, and during service. This separates the three conditions that gate TAKE. Clear strobes are applied in both states, and once together with a new request, to tell a real RETURN from a stray strobe. One cycle carries enable and disable together to fix which of the two wins.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;
    typedef enum logic {
        MAIN_PC    = 1'b0,
        SERVICE_PC = 1'b1
    } pc_state_t;
endpackage

// File: rtl/irq_slot_prio.sv
module irq_slot_prio #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] req,
    output logic                 any,
    output logic [SLOT_W-1:0]    idx
);
    // Scan from the top down so the lowest requesting slot is written last.
    always_comb begin
        idx = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (req[s]) begin
                idx = SLOT_W'(s);
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_stb,
    input  logic dis_stb,
    output logic ien
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien <= 1'b0;
        end else if (dis_stb) begin
            ien <= 1'b0;
        end else if (en_stb) begin
            ien <= 1'b1;
        end
    end

    p_dis_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dis_stb |=> !ien);
    p_en_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stb && !dis_stb) |=> ien);
endmodule

// File: rtl/irq_pc_fsm.sv
module irq_pc_fsm
    import irq_pc_pkg::*;
#(
    parameter int SLOT_W    = 3,
    parameter int REG_IDX_W = 3,
    parameter int MAIN_REG  = 7,
    parameter int SVC_REG   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ien,
    input  logic                 req_any,
    input  logic [SLOT_W-1:0]    req_idx,
    input  logic                 fetch_bnd,
    input  logic                 clr_stb,
    output logic [REG_IDX_W-1:0] pc_sel,
    output logic [SLOT_W-1:0]    win_slot
);
    pc_state_t state_q, state_d;
    logic      take;

    assign take = ien && req_any && fetch_bnd;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAIN_PC:    if (take)    state_d = SERVICE_PC;
            SERVICE_PC: if (clr_stb) state_d = MAIN_PC;
            default:                 state_d = MAIN_PC;
        endcase
    end

    // State register and winner latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MAIN_PC;
            win_slot <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == MAIN_PC && take) begin
                win_slot <= req_idx;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            SERVICE_PC: pc_sel = REG_IDX_W'(SVC_REG);
            default:    pc_sel = REG_IDX_W'(MAIN_REG);
        endcase
    end

    p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == REG_IDX_W'(MAIN_REG) && ien && req_any && fetch_bnd)
        |=> pc_sel == REG_IDX_W'(SVC_REG));
    p_no_bnd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == REG_IDX_W'(MAIN_REG) && !fetch_bnd)
        |=> pc_sel == REG_IDX_W'(MAIN_REG));
    p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == REG_IDX_W'(MAIN_REG) && !ien)
        |=> pc_sel == REG_IDX_W'(MAIN_REG));
    p_hold_svc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == REG_IDX_W'(SVC_REG) && !clr_stb)
        |=> (pc_sel == REG_IDX_W'(SVC_REG) && $stable(win_slot)));
    p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == REG_IDX_W'(SVC_REG) && clr_stb)
        |=> pc_sel == REG_IDX_W'(MAIN_REG));
    p_keep_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == REG_IDX_W'(MAIN_REG) && !take) |=> $stable(win_slot));
endmodule

// File: rtl/irq_pc_switch.sv
module irq_pc_switch #(
    parameter int NUM_SLOTS = 8,
    parameter int REG_IDX_W = 3,
    parameter int MAIN_REG  = 7,
    parameter int SVC_REG   = 6,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic                 irq_en_stb,
    input  logic                 irq_dis_stb,
    input  logic                 irq_clr_stb,
    input  logic                 fetch_bnd,
    output logic [REG_IDX_W-1:0] pc_sel,
    output logic [SLOT_W-1:0]    win_slot
);
    logic              req_any;
    logic [SLOT_W-1:0] req_idx;
    logic              ien;
    logic [NUM_SLOTS-1:0] below_mask;

    irq_slot_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
        .req (slot_req),
        .any (req_any),
        .idx (req_idx)
    );

    irq_enable_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_stb  (irq_en_stb),
        .dis_stb (irq_dis_stb),
        .ien     (ien)
    );

    irq_pc_fsm #(
        .SLOT_W    (SLOT_W),
        .REG_IDX_W (REG_IDX_W),
        .MAIN_REG  (MAIN_REG),
        .SVC_REG   (SVC_REG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien       (ien),
        .req_any   (req_any),
        .req_idx   (req_idx),
        .fetch_bnd (fetch_bnd),
        .clr_stb   (irq_clr_stb),
        .pc_sel    (pc_sel),
        .win_slot  (win_slot)
    );

    assign below_mask = (NUM_SLOTS'(1) << req_idx) - NUM_SLOTS'(1);

    // The encoder result must name a requesting slot with none below it.
    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |-> (slot_req[req_idx] && ((slot_req & below_mask) == '0)));
endmodule

// File: tb/irq_pc_switch_tb_top.sv
module irq_pc_switch_tb_top;
    localparam int CLK_P = 10;
    localparam int NS    = 8;
    localparam int SW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] slot_req = '0;
    logic          irq_en_stb = 1'b0, irq_dis_stb = 1'b0, irq_clr_stb = 1'b0;
    logic          fetch_bnd = 1'b0;
    logic [2:0]    pc_sel;
    logic [SW-1:0] win_slot;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    pc;
        int    slot;
        string tag;
    } exp_t;
    exp_t sb[$];

    // Reference state kept from the requirements
    bit m_ien = 1'b0;
    bit m_svc = 1'b0;
    int m_slot = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_pc_switch #(.NUM_SLOTS(NS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_req    (slot_req),
        .irq_en_stb  (irq_en_stb),
        .irq_dis_stb (irq_dis_stb),
        .irq_clr_stb (irq_clr_stb),
        .fetch_bnd   (fetch_bnd),
        .pc_sel      (pc_sel),
        .win_slot    (win_slot)
    );

    function automatic int lowest(logic [NS-1:0] r);
        for (int i = NS - 1; i >= 0; i--) begin
            if (r[i]) lowest = i;
        end
        if (r == '0) lowest = 0;
    endfunction

    task automatic step(input logic [NS-1:0] req, input bit en, input bit dis,
                        input bit clr, input bit bnd, input string tag);
        exp_t e;
        @(negedge clk);
        slot_req = req; irq_en_stb = en; irq_dis_stb = dis;
        irq_clr_stb = clr; fetch_bnd = bnd;
        if (!m_svc) begin
            if (m_ien && (req != '0) && bnd) begin
                m_svc = 1'b1;
                m_slot = lowest(req);
            end
        end else if (clr) begin
            m_svc = 1'b0;
        end
        if (dis) m_ien = 1'b0;
        else if (en) m_ien = 1'b1;
        e.pc = m_svc ? 6 : 7;
        e.slot = m_slot;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each expected item a quarter period after its edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (int'(pc_sel) != e.pc || int'(win_slot) != e.slot) begin
                    errors++;
                    $display("FAIL %s pc_sel=%0d exp %0d win_slot=%0d exp %0d",
                             e.tag, pc_sel, e.pc, win_slot, e.slot);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        checks++;
        if (pc_sel !== 3'd7 || win_slot !== '0) begin
            errors++;
            $display("FAIL R1 pc_sel=%0d exp 7 win_slot=%0d exp 0", pc_sel, win_slot);
        end
        rst_n = 1'b1;
        step(8'h10, 0, 0, 0, 1, "R1_R4 disabled after reset");
        step(8'h00, 1, 0, 0, 0, "R9 enable");
        step(8'h14, 0, 0, 0, 0, "R3 no boundary");
        step(8'h14, 0, 0, 0, 1, "R2_R5 take slot 2");
        step(8'h01, 0, 0, 0, 1, "R6 ignore in service");
        step(8'h00, 0, 0, 0, 1, "R6 hold");
        step(8'h00, 0, 0, 1, 0, "R7 return");
        step(8'h00, 0, 0, 0, 0, "R10 slot kept");
        step(8'h00, 0, 0, 1, 1, "R8 clear in main");
        step(8'h80, 0, 0, 0, 1, "R2_R5 take slot 7");
        step(8'h80, 0, 0, 1, 1, "R7 clear beats request");
        step(8'h00, 1, 1, 0, 0, "R9 disable wins");
        step(8'h01, 0, 0, 0, 1, "R4 disabled");
        step(8'h00, 1, 0, 0, 0, "R9 re-enable");
        step(8'hFF, 0, 0, 0, 1, "R5 all slots slot 0");
        step(8'h00, 0, 0, 1, 0, "R7 return");
        step(8'h00, 0, 1, 0, 0, "R9 disable");
        step(8'h01, 0, 0, 0, 1, "R4 disabled again");
        step(8'h00, 0, 0, 0, 0, "R10 idle");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule